// File: doc/BRIEF.md
# Round-Robin Four-Target SPI Master

This block is an SPI master that serves four targets on one shared clock, data-out and data-in wiring, each with its own active-low select line. After reset it runs on its own: it opens a transfer to one target, shifts a byte out on MOSI while it shifts a byte in from MISO, and closes the transfer. It then pauses with every select high and moves on to the next target. The targets are visited in a fixed cyclic order, so each one gets a quarter of the transfers.

Each finished transfer produces the received byte, the index of the target that was addressed, and a one-cycle done strobe. It also produces a match flag that says whether the received byte equals a supplied expected byte. The flag keeps its value until the next transfer finishes. When no target is fitted at a select position, the data-in line reads low and the received byte is all zeros. If the expected byte is not zero, that transfer therefore reports no match.

The serial clock runs in SPI mode 0. It idles low, MOSI changes on falling edges, MISO is sampled on rising edges, and the most significant bit goes first. Each serial clock half-period lasts `CLK_DIV` system clocks.

Top module: `spi_rr_master`

## Requirements
- R1: While reset is asserted, all four selects are high, SCLK is low, the done strobe is low and the match flag is low.
- R2: During a transfer exactly one select is low. Transfers rotate through the select patterns 1110, 1101, 1011, 0111 (bit 3 down to bit 0) and then wrap, starting with 1110 after reset. `slave_idx` gives the position of the low bit (0 to 3).
- R3: SCLK is low whenever no select is active. A transfer has exactly 8 rising SCLK edges, and consecutive rising edges are 2*CLK_DIV system clocks apart.
- R4: The `tx_byte` value present when the select goes low is sent on MOSI, MSB first. MOSI never changes at a rising SCLK edge.
- R5: MISO is sampled on each rising SCLK edge, MSB first. The 8 samples form `rx_byte`.
- R6: At the end of each transfer `done` is high for exactly one system clock. In that same cycle `rx_byte` and `slave_idx` are valid for the transfer just finished.
- R7: `match` becomes 1 at completion when the received byte equals `expect_byte`, and 0 otherwise. A transfer to an absent target (MISO low) receives 8'h00 and reports no match when `expect_byte` is nonzero.
- R8: `match` changes only in a cycle in which `done` is high.
- R9: Between two transfers all selects stay high for at least 2*CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_byte | input | 8 | Byte to send in the next transfer |
| expect_byte | input | 8 | Byte the received data is compared with |
| miso | input | 1 | Serial data from the targets |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the targets |
| ss_n | output | 4 | Active-low target selects, one per target |
| rx_byte | output | 8 | Byte received in the last finished transfer |
| slave_idx | output | 2 | Index of the target addressed in the last finished transfer |
| done | output | 1 | One-cycle strobe at transfer completion |
| match | output | 1 | Held result of comparing rx_byte with expect_byte |

## Verification
The bench builds the block with `CLK_DIV` = 3. An odd divider makes any off-by-one in the half-period counter show up as a wrong rising-edge spacing, and it still keeps a full byte under sixty system clocks. Twelve transfers go through the rotation three full times. Target 2 is left absent, so the all-zero no-match path and the wrap from 0111 back to 1110 are both exercised. The data patterns include 8'hFF, 8'h00 and 8'h80.

// File: rtl/spi_rr_pkg.sv
package spi_rr_pkg;
  typedef enum logic {
    ST_GAP  = 1'b0,
    ST_XFER = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/spi_rr_tick.sv
// Free-running divider: one pulse every DIV system clocks marks a half SCLK period.
module spi_rr_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Half-period counter must never pass its terminal value (R3 timing)
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/spi_rr_shift.sv
// Transmit and receive shift registers, MSB first.
module spi_rr_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift_en,
  input  logic         sample_en,
  input  logic [W-1:0] load_val,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx_q, tx_d;
  logic [W-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load)          tx_d = load_val;
    else if (shift_en) tx_d = {tx_q[W-2:0], 1'b0};
    if (sample_en)     rx_d = {rx_q[W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign mosi    = tx_q[W-1];
  assign rx_word = rx_q;

  // Load and shift are driven from different SCLK phases (R4)
  p_no_load_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift_en));
endmodule

// File: rtl/spi_rr_select.sv
// Cyclic target pointer and active-low select decode.
module spi_rr_select #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          adv,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  ss_n
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (adv) idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  for (genvar k = 0; k < N; k++) begin : g_sel
    assign ss_n[k] = !(active && (idx_q == IW'(k)));
  end

  assign idx = idx_q;

  // At most one target selected at a time (R2)
  p_onehot_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ss_n));
  // Pointer wraps from the last target to the first (R2)
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && idx_q == LAST) |=> (idx_q == '0));
endmodule

// File: rtl/spi_rr_master.sv
module spi_rr_master #(
  parameter int DATA_W    = 8,
  parameter int NUM_SLV   = 4,
  parameter int CLK_DIV   = 4,
  parameter int GAP_TICKS = 2,
  parameter int IDX_W     = $clog2(NUM_SLV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic [DATA_W-1:0] expect_byte,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_SLV-1:0] ss_n,
  output logic [DATA_W-1:0] rx_byte,
  output logic [IDX_W-1:0]  slave_idx,
  output logic              done,
  output logic              match
);
  import spi_rr_pkg::*;

  localparam int HALF_W = $clog2(2 * DATA_W);
  localparam int GAP_W  = $clog2(GAP_TICKS + 1);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(2 * DATA_W - 1);
  localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(GAP_TICKS - 1);

  xfer_state_e       state_q, state_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic              sclk_q, sclk_d;
  logic              done_q, done_d;
  logic              match_q, match_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [IDX_W-1:0]  idx_out_q, idx_out_d;

  logic              tick, load, shift_en, sample_en, finish;
  logic [DATA_W-1:0] rx_word;
  logic [IDX_W-1:0]  sel_idx;

  spi_rr_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  spi_rr_shift #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
    .sample_en(sample_en), .load_val(tx_byte), .miso(miso),
    .mosi(mosi), .rx_word(rx_word)
  );

  spi_rr_select #(.N(NUM_SLV), .IW(IDX_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .active(state_q == ST_XFER), .adv(finish),
    .idx(sel_idx), .ss_n(ss_n)
  );

  always_comb begin
    state_d   = state_q;
    half_d    = half_q;
    gap_d     = gap_q;
    sclk_d    = sclk_q;
    load      = 1'b0;
    shift_en  = 1'b0;
    sample_en = 1'b0;
    finish    = 1'b0;
    case (state_q)
      ST_GAP: begin
        if (tick) begin
          if (gap_q == GAP_LAST) begin
            state_d = ST_XFER;
            load    = 1'b1;
            half_d  = '0;
            gap_d   = '0;
          end else begin
            gap_d = gap_q + 1'b1;
          end
        end
      end
      ST_XFER: begin
        if (tick) begin
          sclk_d = !sclk_q;
          half_d = half_q + 1'b1;
          if (!sclk_q) begin
            sample_en = 1'b1;
          end else if (half_q == HALF_LAST) begin
            finish  = 1'b1;
            state_d = ST_GAP;
          end else begin
            shift_en = 1'b1;
          end
        end
      end
      default: state_d = ST_GAP;
    endcase
    done_d    = finish;
    rx_d      = finish ? rx_word : rx_q;
    match_d   = finish ? (rx_word == expect_byte) : match_q;
    idx_out_d = finish ? sel_idx : idx_out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_GAP;
      half_q    <= '0;
      gap_q     <= '0;
      sclk_q    <= 1'b0;
      done_q    <= 1'b0;
      match_q   <= 1'b0;
      rx_q      <= '0;
      idx_out_q <= '0;
    end else begin
      state_q   <= state_d;
      half_q    <= half_d;
      gap_q     <= gap_d;
      sclk_q    <= sclk_d;
      done_q    <= done_d;
      match_q   <= match_d;
      rx_q      <= rx_d;
      idx_out_q <= idx_out_d;
    end
  end

  assign sclk      = sclk_q;
  assign done      = done_q;
  assign match     = match_q;
  assign rx_byte   = rx_q;
  assign slave_idx = idx_out_q;

  // R6: completion strobe lasts a single cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8: compare result held between completions
  p_match_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(match_q));
  // R3: serial clock parked low with no target selected
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&ss_n) |-> !sclk_q);
  // R4: data-out is steady across a rising serial clock edge
  p_mosi_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(mosi));
endmodule

// File: tb/spi_rr_master_bench.sv
`timescale 1ns/1ps
module spi_rr_master_bench;
  localparam int DIV    = 3;
  localparam int NXFER  = 12;
  localparam logic [3:0] PRESENT = 4'b1011;

  typedef struct packed {
    logic [1:0] idx;
    logic [7:0] tx;
    logic [7:0] rx;
    logic       m;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] tx_byte, expect_byte;
  logic       miso, sclk, mosi, done, match;
  logic [3:0] ss_n;
  logic [7:0] rx_byte;
  logic [1:0] slave_idx;

  int n_chk = 0, n_fail = 0;
  item_t sb_q[$];
  logic [7:0] sl_data [4];
  logic [7:0] sl_sh   [4];

  always #2.5 clk = ~clk;

  spi_rr_master #(.CLK_DIV(DIV)) u_spi_rr_master (
    .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte), .expect_byte(expect_byte),
    .miso(miso), .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .rx_byte(rx_byte),
    .slave_idx(slave_idx), .done(done), .match(match)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Target models: absent targets leave MISO low
  always_comb begin
    miso = 1'b0;
    for (int k = 0; k < 4; k++)
      if (!ss_n[k] && PRESENT[k]) miso = sl_sh[k][7];
  end

  // Monitor, target shifting and scoreboard compare
  logic       sclk_p = 1'b0, done_p = 1'b0, match_p = 1'b0;
  logic [3:0] ss_p = 4'hF, ss_seen = 4'hF;
  logic [7:0] mosi_cap = 8'h00;
  int rises = 0, since = 0, gap_len = 0, hold_err = 0;
  bit per_err = 0, seen_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 4; k++) begin
        if (ss_p[k] && !ss_n[k])       sl_sh[k] = sl_data[k];
        else if (sclk_p && !sclk && !ss_n[k]) sl_sh[k] = {sl_sh[k][6:0], 1'b0};
      end
      if ((&ss_p) && !(&ss_n)) begin
        if (seen_done) chk(gap_len >= 2*DIV, "R9 select gap", gap_len, 2*DIV);
        gap_len = 0; rises = 0; per_err = 0;
      end
      if (&ss_n) gap_len++;
      if (sclk && !sclk_p) begin
        if (rises != 0 && since != 2*DIV-1) per_err = 1;
        rises++; since = 0;
        mosi_cap = {mosi_cap[6:0], mosi};
        ss_seen = ss_n;
      end else begin
        since++;
      end
      if (!done && match != match_p) hold_err++;
      if (done) begin
        item_t it;
        chk(!done_p, "R6 done width", done_p, 0);
        if (sb_q.size() == 0) chk(0, "R6 unexpected done", 1, 0);
        else begin
          it = sb_q.pop_front();
          chk(slave_idx == it.idx, "R2 slave_idx", slave_idx, it.idx);
          chk(ss_seen == ~(4'b0001 << it.idx), "R2 select pattern", ss_seen, ~(4'b0001 << it.idx));
          chk(mosi_cap == it.tx, "R4 mosi byte", mosi_cap, it.tx);
          chk(rx_byte == it.rx, "R5 rx_byte", rx_byte, it.rx);
          chk(match == it.m, "R7 match", match, it.m);
          chk(rises == 8 && !per_err, "R3 sclk edges/period", {per_err, 8'(rises)}, 8);
        end
        seen_done = 1;
      end
    end
    sclk_p = sclk; ss_p = ss_n; done_p = done; match_p = match;
  end

  task automatic drive_all();
    for (int n = 0; n < NXFER; n++) begin
      item_t it;
      logic [7:0] d, rx_e, ex;
      int id;
      id = n % 4;
      d  = (n == 1) ? 8'hFF : (n == 4) ? 8'h00 : (n == 5) ? 8'h80 : 8'(8'h01 + n * 8'h29);
      rx_e = PRESENT[id] ? d : 8'h00;
      ex = (n % 3 == 0) ? (rx_e ^ 8'h10) : rx_e;
      if (!PRESENT[id]) ex = 8'h5A;
      tx_byte = 8'hC3 ^ 8'(n * 8'h17);
      expect_byte = ex;
      sl_data[id] = d;
      it.idx = 2'(id); it.tx = tx_byte; it.rx = rx_e; it.m = (rx_e == ex);
      sb_q.push_back(it);
      do @(negedge clk); while (!done);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    bit timeout = 0;
    rst_n = 1'b0;
    tx_byte = 8'h00; expect_byte = 8'h00;
    for (int k = 0; k < 4; k++) begin sl_data[k] = 8'h00; sl_sh[k] = 8'h00; end
    repeat (3) @(negedge clk);
    chk(ss_n == 4'hF, "R1 reset ss_n", ss_n, 4'hF);
    chk(!sclk, "R1 reset sclk", sclk, 0);
    chk(!done, "R1 reset done", done, 0);
    chk(!match, "R1 reset match", match, 0);
    @(posedge clk); rst_n = 1'b1;
    @(negedge clk);
    fork
      drive_all();
      begin repeat (20000) @(posedge clk); timeout = 1; end
    join_any
    disable fork;
    if (timeout) chk(0, "watchdog", 1, 0);
    chk(sb_q.size() == 0, "R6 all transfers completed", sb_q.size(), 0);
    chk(hold_err == 0, "R8 match held between done", hold_err, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule